// File: doc/BRIEF.md
# Dual-Order Burst Offset Sequencer

This block produces the low two bits of a word address for a four-beat burst access. When a new access opens, it captures a 2-bit starting offset and restarts its beat count at zero. Each clock edge on which the active-low advance input is low moves the burst one beat forward. Each edge on which advance is high holds the burst where it is. After the fourth beat, one more advance brings the burst back to its starting offset.

A static order-select input chooses one of two orderings. In linear order each beat adds one to the offset, modulo four. In interleaved order the offset is the starting offset XORed with the beat number. The offset is computed from the stored start value and a small beat counter, so the full sequence is never stored. The upper address bits, the chip-select decode and the storage array belong to the surrounding logic.

The asynchronous active-low reset is released through a two-stage synchroniser. Loads and advances take effect from the third rising edge after reset goes high.

Top module: `bseq_addr_gen`

## Requirements
- R1: While reset is active, and after it is released until the first load, both the offset output and the beat output read 00.
- R2: On a rising edge with `load_i` high, the start offset is captured and the beat count becomes 00. From the following cycle, `ofs_o` equals the captured start value in either order.
- R3: On a rising edge with `load_i` low and `adv_n_i` low, `beat_o` increases by one, modulo four.
- R4: On a rising edge with `load_i` low and `adv_n_i` high, `beat_o` is unchanged, and `ofs_o` is unchanged while `order_sel_i` is unchanged.
- R5: With `order_sel_i` = 1 (interleaved), `ofs_o` equals the start offset XOR `beat_o`. For start 10 the sequence is 10, 11, 00, 01.
- R6: With `order_sel_i` = 0 (linear), `ofs_o` equals the start offset plus `beat_o`, modulo four. For start 10 the sequence is 10, 11, 00, 01, and for start 01 it is 01, 10, 11, 00.
- R7: An advance taken on the fourth beat (`beat_o` = 11) returns `beat_o` to 00 and `ofs_o` to the start offset.
- R8: When `load_i` and an advance occur on the same edge, the load wins. The new start is captured with `beat_o` = 00, and no step is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Opens a new burst and captures `start_ofs_i` |
| adv_n_i | input | 1 | Active-low advance; high suspends the burst |
| order_sel_i | input | 1 | Static strap: 1 interleaved, 0 linear |
| start_ofs_i | input | 2 | Starting low address bits |
| ofs_o | output | 2 | Current low address bits |
| beat_o | output | 2 | Beat index within the burst, 00 to 11 |

## Verification
Every starting offset is run through a full burst plus one wrap step in each order. The interleaved and linear orders give the same sequence for start 00 and 10 but differ for 01 and 11, so those two starts are what separate the orders. Suspend runs, where advance is held high in the middle of a burst, show that holding differs from stepping. Loads that coincide with an advance show that load has priority. A long pseudo-random mix of loads, advances and suspends follows, with both order settings used.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int unsigned OFS_W_DEF = 2;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bseq_rst_sync.sv
module bseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/bseq_start_reg.sv
module bseq_start_reg #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (ld_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (ld_i) q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [W-1:0] beat_o
);
  logic [W-1:0] cnt_r;
  logic [W-1:0] cnt_nxt;
  logic         cnt_en;

  // clear has priority over a step on the same edge
  always_comb begin
    cnt_en  = clr_i | step_i;
    cnt_nxt = cnt_r;
    if (clr_i)       cnt_nxt = '0;
    else if (step_i) cnt_nxt = cnt_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_r <= '0;
    else if (cnt_en) cnt_r <= cnt_nxt;
  end

  assign beat_o = cnt_r;
endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import bseq_pkg::*;
#(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] beat_i,
  input  order_e       order_i,
  output logic [W-1:0] ofs_o
);
  logic [W:0]   carry;
  logic [W-1:0] lin_sum;
  logic [W-1:0] ilv_sum;

  assign carry[0] = 1'b0;

  // per bit: ripple adder for linear order, XOR for interleaved order
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign ilv_sum[i]  = start_i[i] ^ beat_i[i];
    assign lin_sum[i]  = ilv_sum[i] ^ carry[i];
    assign carry[i+1]  = (start_i[i] & beat_i[i]) | (ilv_sum[i] & carry[i]);
    assign ofs_o[i]    = (order_i == ORD_INTERLEAVE) ? ilv_sum[i] : lin_sum[i];
  end

  // the carry out of the top bit is dropped: offsets wrap modulo 2**W
  logic carry_unused;
  assign carry_unused = carry[W];
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen
  import bseq_pkg::*;
#(
  parameter int unsigned OFS_W    = OFS_W_DEF,
  parameter int unsigned RST_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_n_i,
  input  logic             order_sel_i,
  input  logic [OFS_W-1:0] start_ofs_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic [OFS_W-1:0] beat_o
);
  logic             rst_q_n;
  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] beat_q;
  logic             step;
  order_e           order;

  assign step  = ~adv_n_i;
  assign order = order_e'(order_sel_i);

  bseq_rst_sync #(.STAGES(RST_STGS)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  bseq_start_reg #(.W(OFS_W)) u_start (
    .clk   (clk),
    .rst_n (rst_q_n),
    .ld_i  (load_i),
    .d_i   (start_ofs_i),
    .q_o   (start_q)
  );

  bseq_beat_ctr #(.W(OFS_W)) u_beat (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .clr_i  (load_i),
    .step_i (step),
    .beat_o (beat_q)
  );

  bseq_order_map #(.W(OFS_W)) u_map (
    .start_i (start_q),
    .beat_i  (beat_q),
    .order_i (order),
    .ofs_o   (ofs_o)
  );

  assign beat_o = beat_q;
endmodule

// File: rtl/bseq_addr_gen_chk.sv
module bseq_addr_gen_chk #(
  parameter int unsigned W = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_i,
  input logic         adv_n_i,
  input logic         order_sel_i,
  input logic [W-1:0] start_ofs_i,
  input logic [W-1:0] ofs_o,
  input logic [W-1:0] beat_o
);
  // R1
  always_comb begin
    if (!rst_n) begin
      reset_zero_chk: assert (ofs_o == '0 && beat_o == '0);
    end
  end

  // R2 R8
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_o == '0 && ofs_o == $past(start_ofs_i)));

  // R3 R7
  advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i) |=> (beat_o == W'($past(beat_o) + 1'b1)));

  // R4
  suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_n_i) |=> ($stable(beat_o) && ($stable(order_sel_i) -> $stable(ofs_o))));

  // R5
  ilv_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && order_sel_i) |=> (order_sel_i -> ((ofs_o ^ beat_o) == $past(ofs_o ^ beat_o))));

  // R6
  lin_relation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !order_sel_i) |=> (!order_sel_i -> (W'(ofs_o - beat_o) == $past(W'(ofs_o - beat_o)))));
endmodule

bind bseq_addr_gen bseq_addr_gen_chk #(.W(OFS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q_n),
  .load_i      (load_i),
  .adv_n_i     (adv_n_i),
  .order_sel_i (order_sel_i),
  .start_ofs_i (start_ofs_i),
  .ofs_o       (ofs_o),
  .beat_o      (beat_o)
);

// File: tb/sim_bseq_addr_gen.sv
`timescale 1ns/1ps
module sim_bseq_addr_gen;
  logic       clk;
  logic       rst_n;
  logic       load_i;
  logic       adv_n_i;
  logic       order_sel_i;
  logic [1:0] start_ofs_i;
  logic [1:0] ofs_o;
  logic [1:0] beat_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  // behavioural model state
  int m_start = 0;
  int m_beat  = 0;

  bseq_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_n_i(adv_n_i),
    .order_sel_i(order_sel_i), .start_ofs_i(start_ofs_i),
    .ofs_o(ofs_o), .beat_o(beat_o)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic int exp_ofs();
    if (order_sel_i) return m_start ^ m_beat;
    return (m_start + m_beat) % 4;
  endfunction

  task automatic compare(input string tag);
    n_vec++;
    if (int'(ofs_o) != exp_ofs() || int'(beat_o) != m_beat) begin
      n_fail++;
      $display("FAIL %s: ofs=%0d beat=%0d expected ofs=%0d beat=%0d",
               tag, ofs_o, beat_o, exp_ofs(), m_beat);
    end
  endtask

  // drive at negedge, clock, update model, compare at next negedge
  task automatic step(input bit ld, input bit adv_n, input int st, input string tag);
    load_i      = ld;
    adv_n_i     = adv_n;
    start_ofs_i = 2'(st);
    @(posedge clk);
    if (ld) begin
      m_start = st;
      m_beat  = 0;
    end else if (!adv_n) begin
      m_beat = (m_beat + 1) % 4;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    int lfsr;
    rst_n = 0; load_i = 0; adv_n_i = 1; order_sel_i = 1; start_ofs_i = 0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    for (int k = 0; k < 3; k++) step(0, 1, 0, "R1 after release");

    // interleaved order: every start, full burst plus wrap
    order_sel_i = 1;
    for (int s = 0; s < 4; s++) begin
      step(1, 1, s, "R2 load interleaved");
      for (int b = 0; b < 3; b++) step(0, 0, 0, "R5 interleaved beat");
      step(0, 0, 0, "R7 wrap interleaved");
    end
    // linear order
    order_sel_i = 0;
    for (int s = 0; s < 4; s++) begin
      step(1, 1, s, "R2 load linear");
      for (int b = 0; b < 3; b++) step(0, 0, 0, "R6 linear beat");
      step(0, 0, 0, "R7 wrap linear");
    end

    // suspend in the middle of a burst
    step(1, 1, 1, "R2 load before suspend");
    step(0, 0, 0, "R3 advance");
    for (int k = 0; k < 3; k++) step(0, 1, 3, "R4 suspend hold");
    step(0, 0, 0, "R3 advance after suspend");

    // load coinciding with advance
    step(0, 0, 0, "R3 advance");
    step(1, 0, 2, "R8 load beats advance");
    order_sel_i = 1;
    @(negedge clk);
    compare("R5 order switch");
    step(1, 0, 3, "R8 load beats advance interleaved");

    // pseudo-random mix
    lfsr = 32'h1ACE5;
    for (int k = 0; k < 3000; k++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
      if (k % 500 == 0) order_sel_i = lfsr[7];
      step(lfsr[3:0] == 0, lfsr[5], lfsr[9:8], "R3 random mix");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule